// File: doc/BRIEF.md
# Round-Robin Strand Scheduler

This block is the thread-select stage of a fine-grained multithreaded integer pipeline with four hardware strands. Each strand owns one instruction register, loaded by its own fetch-return strobe. In every cycle the scheduler looks for a strand that is both ready and holding a valid instruction. It starts the search at the strand after the one that issued last. It sends the held instruction of the chosen strand to decode, and in the same registered cycle it raises a fetch request for that strand's next instruction.

A strand that has issued a long-latency operation is marked not-ready by a strobe from downstream. The rotation then passes over it and serves the remaining strands. A completion strobe carrying the strand number returns it to the rotation. When no strand qualifies, the stage emits a bubble and leaves its rotation pointer unchanged.

Top module: `strand_sched`

## Requirements
- R1: After synchronous active-high reset, `iss_valid` is 0, `fetch_req` is all zeros, every strand is ready, no instruction register holds a valid instruction, and the rotation pointer is strand 0.
- R2: A strand can be selected only when it is ready and its instruction register holds a valid instruction.
- R3: The search for a strand starts at the strand numbered one above the last issued strand, wrapping from 3 to 0. With all strands eligible, the issue order is 0, 1, 2, 3, 0.
- R4: A strand selected in cycle t appears in cycle t+1 with `iss_valid`=1, `iss_strand` equal to its number, and `iss_instr` equal to the instruction its register held in cycle t.
- R5: `fetch_req` is one-hot at bit `iss_strand` whenever `iss_valid` is 1, and is all zeros whenever `iss_valid` is 0.
- R6: Issuing a strand empties its instruction register. The exception is a fill of the same strand in the selection cycle: that fill is kept and the register stays valid.
- R7: A long-latency strobe (`lat_valid` with `lat_id`) makes that strand not-ready from the next cycle. It is then skipped while the other strands keep rotating.
- R8: A completion strobe (`done_valid` with `done_id`) makes that strand ready from the next cycle. If a completion and a long-latency strobe name the same strand in the same cycle, the strand ends up ready.
- R9: When no strand is eligible, the next cycle shows `iss_valid`=0 and the rotation pointer does not move.
- R10: A fill (`fill_valid[s]` with slice s of `fill_instr`, bits s*32+31 down to s*32) writes that strand's register and marks it valid. A later fill before issue overwrites the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 4 | Per-strand fetch-return strobe |
| fill_instr | input | 128 | Per-strand returned instruction, 32 bits per strand |
| lat_valid | input | 1 | Long-latency operation issued by strand `lat_id` |
| lat_id | input | 2 | Strand becoming not-ready |
| done_valid | input | 1 | Long-latency completion for strand `done_id` |
| done_id | input | 2 | Strand becoming ready |
| iss_valid | output | 1 | Registered issue valid to decode |
| iss_strand | output | 2 | Strand number of the issued instruction |
| iss_instr | output | 32 | Issued instruction |
| fetch_req | output | 4 | One-hot next-fetch request, aligned with the issue |

## Verification
A wrong pointer value shows up on `iss_strand` at the very next issue, provided two or more strands are eligible. A wrong ready or valid bit shows up one cycle after the bench expected that strand to be picked or skipped, as a missing issue, an extra issue, or a bubble where an issue was due. A stale or overwritten instruction register shows up on `iss_instr` in the cycle after that strand is chosen. The bench runs a cycle-accurate model next to the design, so any divergence is reported in the first cycle it appears.

// File: rtl/strand_sched_pkg.sv
package strand_sched_pkg;
  // Successor of a strand index within a ring of n strands.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/strand_ireg_bank.sv
module strand_ireg_bank #(
  parameter int NUM_STRANDS = 4,
  parameter int INSTR_W     = 32,
  localparam int ID_W = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_STRANDS-1:0]         fill_valid,
  input  logic [NUM_STRANDS*INSTR_W-1:0] fill_instr,
  input  logic                           take_valid,
  input  logic [ID_W-1:0]                take_id,
  input  logic [ID_W-1:0]                rd_id,
  output logic [INSTR_W-1:0]             rd_instr,
  output logic [NUM_STRANDS-1:0]         ivalid_q
);
  logic [INSTR_W-1:0] hold_q [NUM_STRANDS];

  // Data storage carries no reset so it maps onto plain registers or RAM.
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_STRANDS; s++) begin
      if (fill_valid[s]) hold_q[s] <= fill_instr[s*INSTR_W +: INSTR_W];
    end
  end

  // Valid bits: fill has priority over consumption by issue.
  for (genvar g = 0; g < NUM_STRANDS; g++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)                                     ivalid_q[g] <= 1'b0;
      else if (fill_valid[g])                      ivalid_q[g] <= 1'b1;
      else if (take_valid && take_id == ID_W'(g))  ivalid_q[g] <= 1'b0;
    end
  end

  assign rd_instr = hold_q[rd_id];
endmodule

// File: rtl/strand_ready_trk.sv
module strand_ready_trk #(
  parameter int NUM_STRANDS = 4,
  localparam int ID_W = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lat_valid,
  input  logic [ID_W-1:0]        lat_id,
  input  logic                   done_valid,
  input  logic [ID_W-1:0]        done_id,
  output logic [NUM_STRANDS-1:0] ready_q
);
  for (genvar g = 0; g < NUM_STRANDS; g++) begin : g_rdy
    logic hit_done, hit_lat;
    assign hit_done = done_valid && (done_id == ID_W'(g));
    assign hit_lat  = lat_valid  && (lat_id  == ID_W'(g));
    always_ff @(posedge clk) begin
      if (rst)           ready_q[g] <= 1'b1;
      else if (hit_done) ready_q[g] <= 1'b1;
      else if (hit_lat)  ready_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/strand_rr_pick.sv
module strand_rr_pick #(
  parameter int NUM_STRANDS = 4,
  localparam int ID_W = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
  input  logic [NUM_STRANDS-1:0] elig,
  input  logic [ID_W-1:0]        start,
  output logic                   found,
  output logic [ID_W-1:0]        pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_STRANDS; k++) begin
      int idx;
      idx = (int'(start) + k) % NUM_STRANDS;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = ID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/strand_sched.sv
module strand_sched #(
  parameter int NUM_STRANDS = 4,
  parameter int INSTR_W     = 32,
  localparam int ID_W = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_STRANDS-1:0]         fill_valid,
  input  logic [NUM_STRANDS*INSTR_W-1:0] fill_instr,
  input  logic                           lat_valid,
  input  logic [ID_W-1:0]                lat_id,
  input  logic                           done_valid,
  input  logic [ID_W-1:0]                done_id,
  output logic                           iss_valid,
  output logic [ID_W-1:0]                iss_strand,
  output logic [INSTR_W-1:0]             iss_instr,
  output logic [NUM_STRANDS-1:0]         fetch_req
);
  import strand_sched_pkg::*;

  logic [NUM_STRANDS-1:0] ready_q;
  logic [NUM_STRANDS-1:0] ivalid_q;
  logic [NUM_STRANDS-1:0] elig;
  logic [ID_W-1:0]        ptr_q;
  logic                   pick_found;
  logic [ID_W-1:0]        pick_id;
  logic [INSTR_W-1:0]     pick_instr;

  strand_ready_trk #(.NUM_STRANDS(NUM_STRANDS)) u_rdy (
    .clk        (clk),
    .rst        (rst),
    .lat_valid  (lat_valid),
    .lat_id     (lat_id),
    .done_valid (done_valid),
    .done_id    (done_id),
    .ready_q    (ready_q)
  );

  strand_ireg_bank #(.NUM_STRANDS(NUM_STRANDS), .INSTR_W(INSTR_W)) u_ireg (
    .clk        (clk),
    .rst        (rst),
    .fill_valid (fill_valid),
    .fill_instr (fill_instr),
    .take_valid (pick_found),
    .take_id    (pick_id),
    .rd_id      (pick_id),
    .rd_instr   (pick_instr),
    .ivalid_q   (ivalid_q)
  );

  assign elig = ready_q & ivalid_q;

  strand_rr_pick #(.NUM_STRANDS(NUM_STRANDS)) u_pick (
    .elig  (elig),
    .start (ptr_q),
    .found (pick_found),
    .pick  (pick_id)
  );

  // Rotation pointer: one past the last issued strand, held on bubbles.
  always_ff @(posedge clk) begin
    if (rst)             ptr_q <= '0;
    else if (pick_found) ptr_q <= ID_W'(ring_next(int'(pick_id), NUM_STRANDS));
  end

  // Registered issue and fetch-request outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_strand <= '0;
      iss_instr  <= '0;
      fetch_req  <= '0;
    end else begin
      iss_valid  <= pick_found;
      iss_strand <= pick_id;
      iss_instr  <= pick_instr;
      fetch_req  <= pick_found ? (NUM_STRANDS'(1) << pick_id) : '0;
    end
  end
endmodule

// File: rtl/strand_sched_chk.sv
module strand_sched_chk #(
  parameter int NUM_STRANDS = 4,
  localparam int ID_W = (NUM_STRANDS > 1) ? $clog2(NUM_STRANDS) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   iss_valid,
  input logic [ID_W-1:0]        iss_strand,
  input logic [NUM_STRANDS-1:0] fetch_req,
  input logic                   lat_valid,
  input logic [ID_W-1:0]        lat_id,
  input logic                   done_valid,
  input logic [ID_W-1:0]        done_id,
  input logic [NUM_STRANDS-1:0] fill_valid,
  input logic [NUM_STRANDS-1:0] ready_q,
  input logic [NUM_STRANDS-1:0] ivalid_q,
  input logic [ID_W-1:0]        ptr_q,
  input logic                   pick_found,
  input logic [ID_W-1:0]        pick_id
);
  a_r5_fetch_follows_issue: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> fetch_req == (NUM_STRANDS'(1) << iss_strand));

  a_r5_no_fetch_on_bubble: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> fetch_req == '0);

  a_r2_pick_is_eligible: assert property (@(posedge clk) disable iff (rst)
    pick_found |-> (ready_q[pick_id] && ivalid_q[pick_id]));

  a_r9_ptr_held_on_bubble: assert property (@(posedge clk) disable iff (rst)
    !pick_found |=> $stable(ptr_q));

  a_r3_ptr_advances: assert property (@(posedge clk) disable iff (rst)
    pick_found |=> ptr_q == (($past(pick_id) == ID_W'(NUM_STRANDS-1)) ? '0 : $past(pick_id) + 1'b1));

  a_r7_lat_blocks: assert property (@(posedge clk) disable iff (rst)
    (lat_valid && !(done_valid && done_id == lat_id)) |=> !ready_q[$past(lat_id)]);

  a_r8_done_restores: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> ready_q[$past(done_id)]);

  a_r6_issue_consumes: assert property (@(posedge clk) disable iff (rst)
    (pick_found && !fill_valid[pick_id]) |=> !ivalid_q[$past(pick_id)]);
endmodule

bind strand_sched strand_sched_chk #(.NUM_STRANDS(NUM_STRANDS)) u_chk (.*);

// File: tb/strand_sched_tb.sv
module strand_sched_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   fill_valid = '0;
  logic [N*W-1:0] fill_instr = '0;
  logic           lat_valid = 1'b0;
  logic [1:0]     lat_id = '0;
  logic           done_valid = 1'b0;
  logic [1:0]     done_id = '0;
  logic           iss_valid;
  logic [1:0]     iss_strand;
  logic [W-1:0]   iss_instr;
  logic [N-1:0]   fetch_req;

  strand_sched #(.NUM_STRANDS(N), .INSTR_W(W)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Model state built from the requirements.
  logic [N-1:0] m_ready, m_valid;
  logic [W-1:0] m_instr [N];
  int           m_ptr;
  logic         e_v;
  int           e_id;
  logic [W-1:0] e_instr;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "iss_valid", longint'(iss_valid), longint'(e_v));
    chk({tag, "/R5"}, "fetch_req", longint'(fetch_req),
        e_v ? longint'(1) << e_id : 0);
    if (e_v) begin
      chk({tag, "/R3"}, "iss_strand", longint'(iss_strand), longint'(e_id));
      chk({tag, "/R4"}, "iss_instr", longint'(iss_instr), longint'(e_instr));
    end
  endtask

  task automatic model_reset();
    m_ready = '1; m_valid = '0; m_ptr = 0;
    e_v = 1'b0; e_id = 0; e_instr = '0;
    for (int s = 0; s < N; s++) m_instr[s] = '0;
  endtask

  // One cycle: at negedge compare last expectation, drive, advance model.
  task automatic step(input string tag, input logic [N-1:0] fv, input logic [N*W-1:0] fi,
                      input logic lv, input int lid, input logic dv, input int did);
    @(negedge clk);
    compare(tag);
    fill_valid = fv; fill_instr = fi;
    lat_valid = lv; lat_id = 2'(lid); done_valid = dv; done_id = 2'(did);
    e_v = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (!e_v && m_ready[idx] && m_valid[idx]) begin
        e_v = 1'b1; e_id = idx; e_instr = m_instr[idx];
      end
    end
    if (e_v) begin
      m_valid[e_id] = 1'b0;
      m_ptr = (e_id + 1) % N;
    end
    for (int s = 0; s < N; s++) begin
      if (fv[s]) begin m_valid[s] = 1'b1; m_instr[s] = fi[s*W +: W]; end
      if (dv && did == s)      m_ready[s] = 1'b1;
      else if (lv && lid == s) m_ready[s] = 1'b0;
    end
  endtask

  function automatic logic [N*W-1:0] pack4(input int base);
    logic [N*W-1:0] v;
    for (int s = 0; s < N; s++) v[s*W +: W] = W'(base + s);
    return v;
  endfunction

  logic [31:0] lfsr = 32'hACE1_1234;
  function automatic logic [31:0] lfsr_next(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: outputs idle after reset, nothing issues with empty registers.
    step("R1", '0, '0, 0, 0, 0, 0);
    step("R1", '0, '0, 0, 0, 0, 0);
    // R3: fill all, expect 0,1,2,3 then R9 bubble.
    step("R3", '1, pack4(32'h100), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R3", '0, '0, 0, 0, 0, 0);
    step("R9", '0, '0, 0, 0, 0, 0);
    step("R9", '0, '0, 0, 0, 0, 0);
    // R7: strand 1 blocked while others rotate with refills (R6 same-cycle fill).
    step("R7", '1, pack4(32'h200), 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) step("R7", '1, pack4(32'h300 + i*16), 0, 0, 0, 0);
    // R8: completion wins over same-cycle long-latency mark.
    step("R8", '0, '0, 1, 1, 1, 1);
    for (int i = 0; i < 5; i++) step("R8", '1, pack4(32'h400 + i*16), 0, 0, 0, 0);
    // R10: block 0,1,3 and drain, then overwrite strand 2 before issue.
    step("R10", '0, '0, 1, 0, 0, 0);
    step("R10", '0, '0, 1, 1, 0, 0);
    step("R10", '0, '0, 1, 3, 0, 0);
    for (int i = 0; i < 5; i++) step("R10", '0, '0, 1, 2, 0, 0);
    step("R10", 4'b0100, pack4(32'h500), 0, 0, 0, 0);
    step("R10", 4'b0100, pack4(32'h600), 0, 0, 0, 0);
    step("R10", '0, '0, 0, 0, 1, 2);
    step("R10", '0, '0, 0, 0, 1, 0);
    step("R10", '0, '0, 0, 0, 1, 1);
    step("R10", '0, '0, 0, 0, 1, 3);
    // R2: pseudo-random sweep of fills, stalls and completions.
    for (int i = 0; i < 4000; i++) begin
      logic [N*W-1:0] fi;
      lfsr = lfsr_next(lfsr);
      fi = pack4(int'(lfsr));
      step("R2", lfsr[3:0] & lfsr[7:4], fi, lfsr[8] & lfsr[9], int'(lfsr[11:10]),
           lfsr[12] & lfsr[13], int'(lfsr[15:14]));
    end
    step("R2", '0, '0, 0, 0, 0, 0);
    @(negedge clk);
    compare("R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule